// File: doc/BRIEF.md
# Numerically Controlled Square-Wave Clock Generator

This block turns a fixed reference clock into one lower-frequency square wave per channel. Each channel has a 16-bit phase accumulator. On every reference cycle the accumulator adds an increment taken from a 16-bit frequency word. The top bit of the accumulator is the channel's output. The resulting frequency is W / 65536 times the reference rate, so a 27 MHz reference with W = 1 gives about 412 Hz.

A word below 0x8000 is used as the increment unchanged. A word at or above 0x8000 is replaced by its 16-bit two's complement, so 0x8000 stays 0x8000 and 0xFFFF becomes 1. The word is written one byte at a time over a shared byte-wide write port. The upper byte is held in a staging register. Only a write of the lower byte moves the full word into use, so a half-written word is never used.

Each channel also gives a one-cycle tick on every rising edge of its output. Downstream logic, such as a fixed-period PWM stage, can use that tick as its count enable. A power-of-two word gives an exact 50% duty cycle, which that use needs. A channel whose start input is low holds its accumulator at zero and keeps its output and tick low. Word writes to a stopped channel are still accepted.

Top module: `nco_clkgen`

## Requirements
- R1: While reset is asserted and right after it, every output and tick is low. Every frequency word and every staged upper byte is zero.
- R2: A write with `wr_hi`=1 only stores `wr_data` as the staged upper byte of the addressed channel. The accumulator increment in use does not change.
- R3: A write with `wr_hi`=0 makes {staged upper byte, `wr_data`} the word in use. The word takes effect from the next reference cycle, so the accumulator step in the write cycle still uses the old word.
- R4: The increment is the word itself when bit 15 is 0, and (65536 - word) mod 65536 when bit 15 is 1. For example 0x8000 gives 0x8000 and 0xFFFF gives 1.
- R5: While its start bit is high, a channel adds the increment to its accumulator every cycle, modulo 2^16. Its output is accumulator bit 15.
- R6: `nco_tick[c]` is high for exactly one cycle, in the first cycle in which `nco_out[c]` is high after being low.
- R7: In the cycle after a cycle with `start[c]` low, the accumulator of channel c is zero and `nco_out[c]` and `nco_tick[c]` are low.
- R8: A write changes only the channel selected by `wr_ch`. Other channels keep their words and waveforms.
- R9: Starting from zero with word 0x0100, over 512 cycles the output is high for exactly 256 cycles and rises twice (50% duty for a power-of-two word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | NUM_CH | Per-channel run enable |
| wr_en | input | 1 | Byte write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_hi | input | 1 | 1 = upper byte (staged), 0 = lower byte (commits word) |
| wr_data | input | BYTE_W | Byte being written |
| nco_out | output | NUM_CH | Square-wave output per channel |
| nco_tick | output | NUM_CH | One-cycle pulse on each output rising edge |

## Verification
A lower-byte commit can land in the same cycle as an accumulator step that produces a rising edge and a tick. The new word must not change that step; it takes effect only on the step after. The bench provokes this collision by committing words at random points while channels run, and on purpose while a channel runs a fast word (0x8000) that ticks every other cycle. A cycle-exact model in the bench updates the old word and the accumulator in the same order the requirements give. Every output and tick is compared with this model on every cycle, so a commit applied one cycle early or late shows up as a waveform mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/nco_word_stage.sv
module nco_word_stage #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  nco_pkg::byte_sel_e wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] upper_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      word_q  <= '0;
    end else if (wr_hit) begin
      if (wr_sel == nco_pkg::SEL_HIGH) upper_q <= wr_data;
      else                             word_q  <= {upper_q, wr_data};
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/nco_incr_map.sv
module nco_incr_map #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] incr_o
);
  always_comb begin
    if (word_i[WORD_W-1]) incr_o = (~word_i) + WORD_W'(1);
    else                  incr_o = word_i;
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] incr,
  output logic [WORD_W-1:0] acc_o,
  output logic              out_o,
  output logic              tick_o
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_nx;
  logic              tick_q;

  assign acc_nx = acc_q + incr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (run) begin
      acc_q  <= acc_nx;
      tick_q <= ~acc_q[WORD_W-1] & acc_nx[WORD_W-1];
    end else begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end
  end

  assign acc_o  = acc_q;
  assign out_o  = acc_q[WORD_W-1];
  assign tick_o = tick_q;
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int NUM_CH = 2,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] start,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NUM_CH-1:0] nco_out,
  output logic [NUM_CH-1:0] nco_tick
);
  logic [NUM_CH*WORD_W-1:0] word_flat;
  logic [NUM_CH*WORD_W-1:0] incr_flat;
  logic [NUM_CH*WORD_W-1:0] acc_flat;
  nco_pkg::byte_sel_e       sel;

  assign sel = wr_hi ? nco_pkg::SEL_HIGH : nco_pkg::SEL_LOW;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(c));

    nco_word_stage #(.BYTE_W(BYTE_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit),
      .wr_sel (sel),
      .wr_data(wr_data),
      .word_o (word_flat[c*WORD_W +: WORD_W])
    );

    nco_incr_map #(.WORD_W(WORD_W)) u_map (
      .word_i(word_flat[c*WORD_W +: WORD_W]),
      .incr_o(incr_flat[c*WORD_W +: WORD_W])
    );

    nco_phase_acc #(.WORD_W(WORD_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start[c]),
      .incr  (incr_flat[c*WORD_W +: WORD_W]),
      .acc_o (acc_flat[c*WORD_W +: WORD_W]),
      .out_o (nco_out[c]),
      .tick_o(nco_tick[c])
    );
  end
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk #(
  parameter int NUM_CH = 2,
  parameter int WORD_W = 16,
  parameter int CH_W = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        start,
  input logic                     wr_en,
  input logic [CH_W-1:0]          wr_ch,
  input logic                     wr_hi,
  input logic [NUM_CH-1:0]        nco_out,
  input logic [NUM_CH-1:0]        nco_tick,
  input logic [NUM_CH*WORD_W-1:0] word_flat,
  input logic [NUM_CH*WORD_W-1:0] incr_flat,
  input logic [NUM_CH*WORD_W-1:0] acc_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      nco_tick[c] |-> (nco_out[c] && !$past(nco_out[c]))); // R6
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nco_tick[c] |=> !nco_tick[c]); // R6
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !start[c] |=> (!nco_out[c] && !nco_tick[c] && acc_flat[c*WORD_W +: WORD_W] == '0)); // R7
    AST_HI_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi && wr_ch == CH_W'(c)) |=> $stable(word_flat[c*WORD_W +: WORD_W])); // R2
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |=> (acc_flat[c*WORD_W +: WORD_W] ==
                    $past(acc_flat[c*WORD_W +: WORD_W]) + $past(incr_flat[c*WORD_W +: WORD_W]))); // R5
    AST_OTHER_CH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch != CH_W'(c)) |=> $stable(word_flat[c*WORD_W +: WORD_W])); // R8
  end
endmodule

bind nco_clkgen nco_clkgen_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wr_en    (wr_en),
  .wr_ch    (wr_ch),
  .wr_hi    (wr_hi),
  .nco_out  (nco_out),
  .nco_tick (nco_tick),
  .word_flat(word_flat),
  .incr_flat(incr_flat),
  .acc_flat (acc_flat)
);

// File: tb/nco_clkgen_test.sv
module nco_clkgen_test;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] start = '0;
  logic           wr_en = 1'b0;
  logic [0:0]     wr_ch = '0;
  logic           wr_hi = 1'b0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] nco_out;
  logic [NCH-1:0] nco_tick;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";
  int    hi_cnt;
  int    rise_cnt;

  logic [7:0]  m_up  [NCH];
  logic [15:0] m_word[NCH];
  logic [15:0] m_acc [NCH];
  logic        m_tick[NCH];

  always #2 clk = ~clk;

  nco_clkgen #(.NUM_CH(NCH), .BYTE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_hi(wr_hi), .wr_data(wr_data), .nco_out(nco_out), .nco_tick(nco_tick)
  );

  function automatic logic [15:0] incr_of(logic [15:0] w);
    return w[15] ? 16'((~w) + 16'd1) : w;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [NCH-1:0] st, logic we, logic ch, logic hi, logic [7:0] d);
    start = st; wr_en = we; wr_ch = ch; wr_hi = hi; wr_data = d;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] nx;
      nx = m_acc[c] + incr_of(m_word[c]);
      if (st[c]) begin
        m_tick[c] = ~m_acc[c][15] & nx[15];
        m_acc[c]  = nx;
      end else begin
        m_tick[c] = 1'b0;
        m_acc[c]  = '0;
      end
      if (we && ch == 1'(c)) begin
        if (hi) m_up[c] = d;
        else    m_word[c] = {m_up[c], d};
      end
    end
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(req, 32'(nco_out[c]), 32'(m_acc[c][15]));
      chk(req, 32'(nco_tick[c]), 32'(m_tick[c]));
    end
  endtask

  task automatic put_word(logic [NCH-1:0] st, logic ch, logic [15:0] w);
    cyc(st, 1'b1, ch, 1'b1, w[15:8]);
    cyc(st, 1'b1, ch, 1'b0, w[7:0]);
  endtask

  task automatic idle(logic [NCH-1:0] st, int n);
    for (int i = 0; i < n; i++) cyc(st, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_up[c] = '0; m_word[c] = '0; m_acc[c] = '0; m_tick[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    req = "R1";
    chk("R1", 32'(nco_out), 32'h0);
    chk("R1", 32'(nco_tick), 32'h0);
    rst_n = 1'b1;
    idle(2'b11, 4);

    // R4: 0x8000 maps to itself, toggles every cycle; tick collides with commits
    req = "R4";
    put_word(2'b00, 1'b0, 16'h8000);
    idle(2'b01, 20);
    req = "R3";
    put_word(2'b01, 1'b0, 16'h4000);
    idle(2'b01, 12);
    req = "R4";
    put_word(2'b01, 1'b0, 16'hC000);
    idle(2'b01, 12);

    // R9: power-of-two duty cycle from a fresh start
    req = "R9";
    put_word(2'b00, 1'b0, 16'h0100);
    hi_cnt = 0; rise_cnt = 0;
    for (int i = 0; i < 512; i++) begin
      cyc(2'b01, 1'b0, 1'b0, 1'b0, 8'h00);
      hi_cnt += int'(nco_out[0]);
      rise_cnt += int'(nco_tick[0]);
    end
    chk("R9", 32'(hi_cnt), 32'd256);
    chk("R9", 32'(rise_cnt), 32'd2);

    // R2: upper byte alone leaves the running waveform unchanged
    req = "R2";
    cyc(2'b01, 1'b1, 1'b0, 1'b1, 8'h7F);
    hi_cnt = 0;
    for (int i = 0; i < 512; i++) begin
      cyc(2'b01, 1'b0, 1'b0, 1'b0, 8'h00);
      hi_cnt += int'(nco_out[0]);
    end
    chk("R2", 32'(hi_cnt), 32'd256);

    // R3: lower byte commits staged upper byte
    req = "R3";
    cyc(2'b01, 1'b1, 1'b0, 1'b0, 8'h33);
    idle(2'b01, 60);

    // R7: stopping while committing a word
    req = "R7";
    cyc(2'b00, 1'b1, 1'b0, 1'b0, 8'h01);
    chk("R7", 32'(nco_out[0]), 32'h0);
    idle(2'b00, 10);
    chk("R7", 32'(nco_tick[0]), 32'h0);

    // R8: channel 1 alone, channel 0 held with its word
    req = "R8";
    put_word(2'b01, 1'b1, 16'hFFFF);
    put_word(2'b11, 1'b1, 16'h2000);
    idle(2'b11, 100);

    // R5 R6: random writes, starts and words
    req = "R5 R6";
    for (int i = 0; i < 3000; i++) begin
      logic [NCH-1:0] st;
      logic [7:0] d;
      st = (($urandom % 16) == 0) ? NCH'($urandom) : start;
      d = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
      cyc(st, ($urandom % 4) == 0, 1'($urandom), 1'($urandom), d);
    end
    idle(2'b11, 20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule